// File: doc/BRIEF.md
# Bus Wait-State READY Generator

This block produces the active-high READY input of a 16-bit CPU that runs from a clock of roughly 333 ns. Three independent sources can stall the processor, and READY is high only when none of them does. First, every external memory cycle is checked against its 8-bit physical page number. A small fast window of pages runs at full speed. Every other page costs one wait state on the first cycle of the access. Second, after a read or write of the video controller, a 4-bit counter opens a recovery window that stalls the next bus cycles. This window is optional and is controlled by an enable bit. Third, a not-ready line from a slow sound device can hold READY low directly.

The video window does not start during the access itself. It starts on the clock edge at which the block first sees both chip selects inactive after one of them was active. A mode bit then picks one of two release patterns. In clean mode, READY stays low until the counter reaches its top value. In early mode, READY first rises at count 9. From there it follows the counter's least significant bit until the top value.

The CPU has a single active-low strobe that is shared between memory writes and the bit-serial I/O clock. The block splits this strobe into two separate active-low outputs, a write enable and an I/O clock, using the memory-cycle flag.

Top module: `wsg_ready_gen`

## Requirements
- R1: After reset is released, with no access in progress, ready_o is 1. The video counter resets to its idle value of 15.
- R2: A memory cycle (mem_cycle_i=1) to a page whose bits [7:3] equal 5'b11101 (pages 0xE8 to 0xEF) never pulls ready_o low.
- R3: A memory cycle to any other page pulls ready_o low in exactly one cycle. That cycle is the first one in which mem_cycle_i is 1 after being 0 at the previous clock edge. From the second cycle on, the page adds no wait. Outside memory cycles, the page number has no effect.
- R4: With vwait_en_i=1 and wait_mode_i=1 (clean), a video access ends at the first clock edge that samples vid_rd_i=vid_wr_i=0 after either was 1. That edge loads the counter with 0. The counter then advances by one per clock up to 15 and stays there. ready_o is low for counts 0 to 14, which is 15 cycles, and high at 15.
- R5: With vwait_en_i=1 and wait_mode_i=0 (early), the video term is low for counts 0 to 8. From count 9 it equals the counter's bit 0, and it is high at 15.
- R6: While vwait_en_i=0, the counter is forced to 15 at every edge, so video accesses never pull ready_o low. Clearing the enable during a count ends the window at the next edge.
- R7: A video access that ends while a count is running restarts the count at 0. A select that is held active while the count runs does not pause or extend the count.
- R8: snd_busy_i=1 forces ready_o to 0 in the same cycle, whatever the other sources are doing.
- R9: ready_o is the AND of the sound term, the page term and the video term.
- R10: we_no is low only when strobe_ni=0 and mem_cycle_i=1. cru_clk_no is low only when strobe_ni=0 and mem_cycle_i=0. The two outputs are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_cycle_i | input | 1 | External memory cycle in progress, active high |
| page_i | input | 8 | Physical page number of the current access |
| vid_rd_i | input | 1 | Video controller read select, active high |
| vid_wr_i | input | 1 | Video controller write select, active high |
| snd_busy_i | input | 1 | Sound device not ready, active high |
| vwait_en_i | input | 1 | Enables the post-access video wait window |
| wait_mode_i | input | 1 | Video release pattern: 1 = clean, 0 = early |
| strobe_ni | input | 1 | Shared CPU write / I/O clock strobe, active low |
| ready_o | output | 1 | READY to the CPU, active high |
| we_no | output | 1 | Memory write enable, active low |
| cru_clk_no | output | 1 | Bit-serial I/O clock, active low |

## Verification
The sound, page and strobe terms are combinational, so each of them is due in the same cycle as the input that causes it. The page term also depends on the memory-cycle flag registered at the previous edge. The video term changes one edge after the release of the select is sampled: the first low cycle comes right after that edge, and the release pattern is set by the number of edges since then. The bench drives inputs on the falling edge and compares all three outputs with its behavioural model shortly afterwards. It advances the model's edge count and last-sampled flags only at the rising edge, so each expectation falls in the cycle in which the result is due.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  typedef enum logic {
    WMODE_EARLY = 1'b0,
    WMODE_CLEAN = 1'b1
  } wait_mode_e;
endpackage

// File: rtl/wsg_page_wait.sv
module wsg_page_wait #(
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned FAST_LOG2 = 3,
  parameter logic [PAGE_W-1:0] FAST_BASE = 8'hE8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_cycle_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              page_ok_o
);
  localparam int unsigned TAG_W = PAGE_W - FAST_LOG2;

  logic mem_q;
  logic fast_page;
  logic first_cyc;

  assign fast_page = (page_i[PAGE_W-1:FAST_LOG2] == FAST_BASE[PAGE_W-1:FAST_LOG2]);
  assign first_cyc = mem_cycle_i && !mem_q;
  assign page_ok_o = !(first_cyc && !fast_page);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= 1'b0;
    else         mem_q <= mem_cycle_i;
  end

  // R2
  fast_no_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cycle_i && page_i[PAGE_W-1:FAST_LOG2] == TAG_W'(FAST_BASE >> FAST_LOG2)) |-> page_ok_o);
  // R3
  one_wait_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cycle_i && !page_ok_o) |=> (mem_cycle_i -> page_ok_o));
endmodule

// File: rtl/wsg_video_wait.sv
module wsg_video_wait
  import wsg_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned EARLY_AT = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mode_i,
  input  logic sel_i,
  output logic vid_ok_o
);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_EARLY = CNT_W'(EARLY_AT);

  logic [CNT_W-1:0] cnt_q;
  logic             sel_q;
  logic             release_ev;
  logic             at_top;

  assign release_ev = sel_q && !sel_i;
  assign at_top     = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_MAX;
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel_i;
      if (!en_i)           cnt_q <= CNT_MAX;
      else if (release_ev) cnt_q <= '0;
      else if (!at_top)    cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  generate
    if (EARLY_AT < (1 << CNT_W) - 1) begin : g_early
      logic early_ok;
      assign early_ok = (cnt_q >= CNT_EARLY) && cnt_q[0];
      assign vid_ok_o = at_top || ((wait_mode_e'(mode_i) == WMODE_EARLY) && early_ok);
    end else begin : g_clean
      assign vid_ok_o = at_top;
    end
  endgenerate

  // R4
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sel_q && !sel_i) |=> (cnt_q == '0 && !vid_ok_o));
  // R4
  clean_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && $rose(vid_ok_o)) |-> (cnt_q == CNT_MAX));
  // R6
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> vid_ok_o);
  // R7
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_top && !(en_i && release_ev)) |=> at_top);
endmodule

// File: rtl/wsg_strobe_split.sv
module wsg_strobe_split (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mem_cycle_i,
  input  logic strobe_ni,
  output logic we_no,
  output logic cru_clk_no
);
  assign we_no      = strobe_ni || !mem_cycle_i;
  assign cru_clk_no = strobe_ni || mem_cycle_i;

  // R10
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!we_no, !cru_clk_no}));
  // R10
  strobe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_ni |-> (we_no && cru_clk_no));
endmodule

// File: rtl/wsg_ready_gen.sv
module wsg_ready_gen #(
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned FAST_LOG2 = 3,
  parameter logic [PAGE_W-1:0] FAST_BASE = 8'hE8,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned EARLY_AT  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_cycle_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              vid_rd_i,
  input  logic              vid_wr_i,
  input  logic              snd_busy_i,
  input  logic              vwait_en_i,
  input  logic              wait_mode_i,
  input  logic              strobe_ni,
  output logic              ready_o,
  output logic              we_no,
  output logic              cru_clk_no
);
  logic page_ok;
  logic vid_ok;

  wsg_page_wait #(
    .PAGE_W(PAGE_W), .FAST_LOG2(FAST_LOG2), .FAST_BASE(FAST_BASE)
  ) u_page (
    .clk_i(clk_i), .rst_ni(rst_ni), .mem_cycle_i(mem_cycle_i),
    .page_i(page_i), .page_ok_o(page_ok)
  );

  wsg_video_wait #(.CNT_W(CNT_W), .EARLY_AT(EARLY_AT)) u_video (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(vwait_en_i), .mode_i(wait_mode_i),
    .sel_i(vid_rd_i || vid_wr_i), .vid_ok_o(vid_ok)
  );

  wsg_strobe_split u_strobe (
    .clk_i(clk_i), .rst_ni(rst_ni), .mem_cycle_i(mem_cycle_i),
    .strobe_ni(strobe_ni), .we_no(we_no), .cru_clk_no(cru_clk_no)
  );

  assign ready_o = !snd_busy_i && page_ok && vid_ok;

  // R8
  snd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snd_busy_i |-> !ready_o);
  // R9
  ready_and_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (page_ok && vid_ok));
endmodule

// File: tb/wsg_ready_gen_tb.sv
module wsg_ready_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mem_cycle = 1'b0;
  logic [7:0] page = 8'h00;
  logic       vid_rd = 1'b0, vid_wr = 1'b0, snd_busy = 1'b0;
  logic       ven = 1'b0, wmode = 1'b1, strobe_n = 1'b1;
  logic       ready, we_n, cru_n;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // model state
  int  m_phase = 15;
  bit  m_sel_prev = 1'b0;
  bit  m_mem_prev = 1'b0;

  always #5 clk = ~clk;

  wsg_ready_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mem_cycle_i(mem_cycle), .page_i(page),
    .vid_rd_i(vid_rd), .vid_wr_i(vid_wr), .snd_busy_i(snd_busy),
    .vwait_en_i(ven), .wait_mode_i(wmode), .strobe_ni(strobe_n),
    .ready_o(ready), .we_no(we_n), .cru_clk_no(cru_n)
  );

  function automatic bit exp_ready();
    bit fast, pg_ok, vid_ok;
    fast   = (page >= 8'hE8) && (page <= 8'hEF);
    pg_ok  = !(mem_cycle && !m_mem_prev && !fast);
    vid_ok = (m_phase >= 15) || (!wmode && m_phase >= 9 && (m_phase % 2 == 1));
    return !snd_busy && pg_ok && vid_ok;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // inputs already applied at a falling edge; check, then advance one clock
  task automatic cyc(string tag);
    bit sel;
    #2;
    chk(tag, ready, exp_ready());
    chk("R10", we_n, !(!strobe_n && mem_cycle));
    chk("R10", cru_n, !(!strobe_n && !mem_cycle));
    sel = vid_rd || vid_wr;
    @(posedge clk);
    if (!ven)                   m_phase = 15;
    else if (m_sel_prev && !sel) m_phase = 0;
    else if (m_phase < 15)      m_phase++;
    m_sel_prev = sel;
    m_mem_prev = mem_cycle;
    @(negedge clk);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic mem_acc(logic [7:0] pg, int len, string tag);
    page = pg; mem_cycle = 1'b1;
    for (int i = 0; i < len; i++) cyc(tag);
    mem_cycle = 1'b0;
    cyc(tag);
  endtask

  task automatic vid_acc(bit wr, int len, string tag);
    vid_rd = !wr; vid_wr = wr;
    for (int i = 0; i < len; i++) cyc(tag);
    vid_rd = 1'b0; vid_wr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", ready, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk);
    idle("R1", 3);

    // R2 fast pages
    mem_acc(8'hE8, 3, "R2");
    mem_acc(8'hEF, 2, "R2");
    // R3 slow pages
    mem_acc(8'h00, 3, "R3");
    mem_acc(8'hC0, 2, "R3");
    mem_acc(8'hE7, 3, "R3");
    mem_acc(8'hF0, 1, "R3");
    page = 8'h10; idle("R3", 2); // page without memory cycle has no effect
    // R10 strobe split
    page = 8'hE9; mem_cycle = 1'b1; strobe_n = 1'b0; cyc("R10");
    mem_cycle = 1'b0; cyc("R10"); strobe_n = 1'b1; cyc("R10");

    // R4 clean mode
    ven = 1'b1; wmode = 1'b1;
    vid_acc(1'b0, 2, "R4");
    idle("R4", 18);
    // R5 early mode
    wmode = 1'b0;
    vid_acc(1'b1, 1, "R5");
    idle("R5", 18);
    // R7 restart during count, and held select does not extend
    wmode = 1'b1;
    vid_acc(1'b0, 1, "R7");
    idle("R7", 5);
    vid_acc(1'b1, 3, "R7");
    idle("R7", 17);
    vid_acc(1'b0, 1, "R7");
    idle("R7", 4);
    vid_rd = 1'b1; idle("R7", 14); vid_rd = 1'b0; idle("R7", 17);
    // R6 enable off
    ven = 1'b0;
    vid_acc(1'b1, 2, "R6");
    idle("R6", 4);
    ven = 1'b1;
    vid_acc(1'b0, 1, "R6");
    idle("R6", 3);
    ven = 1'b0; idle("R6", 2);
    chk("R6", ready, 1'b1);
    ven = 1'b1;
    // R8 / R9 sound and combined sources
    snd_busy = 1'b1; idle("R8", 3);
    mem_cycle = 1'b1; page = 8'hEA; cyc("R8");
    snd_busy = 1'b0; cyc("R9"); mem_cycle = 1'b0; cyc("R9");
    wmode = 1'b0;
    vid_acc(1'b1, 1, "R9");
    idle("R9", 2);
    page = 8'h40; mem_cycle = 1'b1; idle("R9", 8);
    snd_busy = 1'b1; idle("R9", 2); snd_busy = 1'b0;
    mem_cycle = 1'b0; idle("R9", 12);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule